// File: doc/BRIEF.md
# Conversion-Ready and Resynchronization Controller

This block sits in the digital back end of a decimating converter. It counts system clocks at a programmable decimation ratio and, at the end of each conversion period, pulses an output-register load enable. Around every load it drives an active-low ready flag. The flag rises one clock before the load, so a host never reads while the result register is being rewritten. It falls one clock after the load to announce fresh data. It rises again once the host reports that it has finished reading the data register.

Two sources can realign conversions with an outside event. The first is an asynchronous active-low sync pin, which passes through a two-stage synchronizer. While the synchronized pin is low, the decimation counter is held at zero and the modulator-reset output stays asserted. Counting starts again on the first clock after the synchronized pin goes high. The second is a one-cycle command strobe, which gives the same restart with a one-cycle hold. The ratio is captured only when the counter returns to zero, and any value below three is treated as three.

Top module: `drdy_sync_ctrl`

## Requirements
- R1: With an effective ratio N and no hold, `oreg_load` is high for one cycle every N clocks. The first load comes N clocks after the clock edge that ends a hold.
- R2: `drdy_n` is low in the cycle after every `oreg_load` pulse, unless a hold is active in the load cycle.
- R3: `drdy_n` is high in the cycle of every `oreg_load` pulse and in the cycle before it.
- R4: A `rd_done` pulse while `oreg_load` is low makes `drdy_n` high in the next cycle.
- R5: `drdy_n` falls only in the cycle directly after a load. While a hold lasts, it keeps its value unless `rd_done` arrives.
- R6: Three clock edges after `sync_n` is sampled low, `mod_rst` is high. It stays high while the pin stays low, and the decimation counter stays at zero.
- R7: `oreg_load` is never high in a cycle where `mod_rst` is high.
- R8: A one-cycle `sync_cmd` pulse sets `mod_rst` high for the following cycle and restarts the counter. The next load then comes N clocks after the clock edge that samples the strobe.
- R9: A `dec_ratio` value of 0, 1 or 2 acts as a ratio of 3, so loads are never closer than three cycles apart.
- R10: `dec_ratio` is sampled only when the counter returns to zero, which happens at a load, during a hold, or at reset. A change in mid-period takes effect from the next period.
- R11: While `rst` is high, `drdy_n` is 1, `oreg_load` is 0 and `mod_rst` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Asynchronous active-low synchronization pin |
| sync_cmd | input | 1 | One-cycle synchronous resynchronization command |
| rd_done | input | 1 | One-cycle strobe: host finished reading the data register |
| dec_ratio | input | RATIO_W | Decimation ratio in clocks per conversion |
| oreg_load | output | 1 | Output-register load enable, one cycle per conversion |
| drdy_n | output | 1 | Active-low data-ready flag |
| mod_rst | output | 1 | Modulator reset, high during a sync hold |

## Verification
The properties assume that `sync_cmd` and `rd_done` are synchronous pulses one cycle wide. They place no limit on how long or how often `sync_n` may toggle, and `dec_ratio` may change on any cycle. The stimulus changes every input on the falling clock edge. It issues `rd_done` only after the ready flag has fallen, which is how a host behaves. It lowers the sync pin or issues the command only in the cycles around a completed load, so the scoreboard can state exactly which loads must still appear and which must be suppressed.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
  // smallest period that leaves room for flag-high, load and flag-low
  localparam int unsigned MIN_RATIO = 3;

  // per-cycle events produced by the decimation counter
  typedef struct packed {
    logic pre;   // one clock before the load
    logic load;  // period end: load the output register
  } dec_evt_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned STAGES   = 2,
  parameter logic        IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stg;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= IDLE_VAL;
          else     stg[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= IDLE_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/decim_counter.sv
module decim_counter
  import drdy_pkg::*;
#(
  parameter int unsigned RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold,
  input  logic [RATIO_W-1:0] ratio,
  output dec_evt_t           evt
);
  localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(MIN_RATIO);

  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] ratio_eff;
  logic               at_end;
  logic               at_pre;

  assign ratio_eff = (ratio < MIN_R) ? MIN_R : ratio;
  assign at_end    = (cnt == ratio_q - RATIO_W'(1));
  assign at_pre    = (cnt == ratio_q - RATIO_W'(2));

  // ratio is only captured when the count returns to zero
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      ratio_q <= ratio_eff;
    end else if (hold || at_end) begin
      cnt     <= '0;
      ratio_q <= ratio_eff;
    end else begin
      cnt     <= cnt + RATIO_W'(1);
    end
  end

  always_comb begin
    evt.pre  = at_pre && !hold;
    evt.load = at_end && !hold;
  end
endmodule

// File: rtl/ready_flag.sv
module ready_flag
  import drdy_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hold,
  input  dec_evt_t evt,
  input  logic     rd_done,
  output logic     oreg_load,
  output logic     drdy_n,
  output logic     mod_rst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      oreg_load <= 1'b0;
      drdy_n    <= 1'b1;
      mod_rst   <= 1'b0;
    end else begin
      oreg_load <= evt.load;
      mod_rst   <= hold;
      // priority: block reads before the load, announce after it,
      // then a completed read clears the flag
      if (evt.pre)                 drdy_n <= 1'b1;
      else if (oreg_load && !hold) drdy_n <= 1'b0;
      else if (rd_done)            drdy_n <= 1'b1;
    end
  end
endmodule

// File: rtl/drdy_sync_ctrl.sv
module drdy_sync_ctrl
  import drdy_pkg::*;
#(
  parameter int unsigned RATIO_W     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_n,
  input  logic               sync_cmd,
  input  logic               rd_done,
  input  logic [RATIO_W-1:0] dec_ratio,
  output logic               oreg_load,
  output logic               drdy_n,
  output logic               mod_rst
);
  logic     pin_lvl;
  logic     hold;
  dec_evt_t evt;

  sync_chain #(
    .STAGES   (SYNC_STAGES),
    .IDLE_VAL (1'b1)
  ) u_pin (
    .clk  (clk),
    .rst  (rst),
    .din  (sync_n),
    .dout (pin_lvl)
  );

  // a low synchronized pin or a command strobe freezes the counter
  assign hold = !pin_lvl || sync_cmd;

  decim_counter #(
    .RATIO_W (RATIO_W)
  ) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .hold  (hold),
    .ratio (dec_ratio),
    .evt   (evt)
  );

  ready_flag u_flag (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .evt       (evt),
    .rd_done   (rd_done),
    .oreg_load (oreg_load),
    .drdy_n    (drdy_n),
    .mod_rst   (mod_rst)
  );
endmodule

// File: rtl/drdy_sync_chk.sv
module drdy_sync_chk (
  input logic clk,
  input logic rst,
  input logic sync_n,
  input logic sync_cmd,
  input logic rd_done,
  input logic oreg_load,
  input logic drdy_n,
  input logic mod_rst
);
  int unsigned since_rst;
  int unsigned since_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst  <= 0;
      since_load <= 100;
    end else begin
      if (since_rst < 100) since_rst <= since_rst + 1;
      if (oreg_load)              since_load <= 0;
      else if (since_load < 100)  since_load <= since_load + 1;
    end
  end

  p_fall_after_load_r2: assert property (@(posedge clk) disable iff (rst)
    oreg_load |=> (!drdy_n || mod_rst));

  p_high_around_load_r3: assert property (@(posedge clk) disable iff (rst)
    oreg_load |-> (drdy_n && $past(drdy_n)));

  p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !oreg_load) |=> drdy_n);

  p_fall_only_post_load_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(drdy_n) |-> $past(oreg_load));

  p_pin_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3 && !$past(sync_n, 3)) |-> mod_rst);

  p_no_load_held_r7: assert property (@(posedge clk) disable iff (rst)
    mod_rst |-> !oreg_load);

  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (rst)
    sync_cmd |=> mod_rst);

  p_load_gap_r9: assert property (@(posedge clk) disable iff (rst)
    oreg_load |-> (since_load >= 2));
endmodule

bind drdy_sync_ctrl drdy_sync_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sync_n    (sync_n),
  .sync_cmd  (sync_cmd),
  .rd_done   (rd_done),
  .oreg_load (oreg_load),
  .drdy_n    (drdy_n),
  .mod_rst   (mod_rst)
);

// File: tb/sim_drdy_sync_ctrl.sv
module sim_drdy_sync_ctrl;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         sync_n;
  logic         sync_cmd;
  logic         rd_done;
  logic [W-1:0] dec_ratio;
  logic         oreg_load;
  logic         drdy_n;
  logic         mod_rst;

  always #5 clk = ~clk;

  drdy_sync_ctrl #(.RATIO_W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .sync_n(sync_n), .sync_cmd(sync_cmd),
    .rd_done(rd_done), .dec_ratio(dec_ratio), .oreg_load(oreg_load),
    .drdy_n(drdy_n), .mod_rst(mod_rst)
  );

  int edges = 0;
  always @(posedge clk) if (!rst) edges <= edges + 1;

  int n_chk  = 0;
  int n_fail = 0;
  int expq[$];
  logic prev_load = 1'b0;
  logic prev_drdy = 1'b1;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_loads(input int base, input int r, input int n);
    for (int k = 1; k <= n; k++) expq.push_back(base + k * r);
  endtask

  task automatic wait_to(input int t);
    while (edges < t) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    int e;
    if (!rst && !done) begin
      if (oreg_load) begin
        if (expq.size() == 0) chk(1'b0, "R7 load not expected", edges, -1);
        else begin
          e = expq.pop_front();
          chk(edges == e, "R1 load cycle", edges, e);
        end
        chk(drdy_n && prev_drdy, "R3 flag high before and at load",
            int'({prev_drdy, drdy_n}), 3);
      end
      if (prev_load) chk(!drdy_n, "R2 flag low after load", drdy_n, 0);
      prev_load = oreg_load;
      prev_drdy = drdy_n;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog all requirements", 0, 1);
    done = 1'b1;
    finish_up();
  end

  initial begin
    int m;
    int l;
    rst = 1'b1; sync_n = 1'b0; sync_cmd = 1'b0; rd_done = 1'b0; dec_ratio = 16'd5;
    repeat (3) @(negedge clk);
    chk(drdy_n == 1'b1,    "R11 reset drdy_n",    drdy_n, 1);
    chk(oreg_load == 1'b0, "R11 reset oreg_load", oreg_load, 0);
    chk(mod_rst == 1'b0,   "R11 reset mod_rst",   mod_rst, 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk(mod_rst == 1'b1, "R6 pin low holds", mod_rst, 1);
    chk(drdy_n == 1'b1,  "R5 no fall while held", drdy_n, 1);

    // restart with ratio 6 sampled at the release edge (R10)
    dec_ratio = 16'd6;
    m = edges;
    sync_n = 1'b1;
    push_loads(m + 2, 6, 4);
    wait_to(m + 9);
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    chk(drdy_n == 1'b1, "R4 read clears flag", drdy_n, 1);
    wait_to(m + 26);
    sync_n = 1'b0;
    dec_ratio = 16'd1;
    repeat (6) @(negedge clk);
    chk(mod_rst == 1'b1, "R6 pin low holds again", mod_rst, 1);
    chk(drdy_n == 1'b0,  "R5 flag kept during hold", drdy_n, 0);

    // ratio 1 clamps to 3 (R9)
    m = edges;
    sync_n = 1'b1;
    push_loads(m + 2, 3, 3);
    l = m + 11;
    wait_to(l);
    // R10: change mid-run, current period keeps ratio 3
    dec_ratio = 16'd7;
    expq.push_back(l + 3);
    push_loads(l + 3, 7, 2);
    wait_to(l + 18);
    // R8: command restart
    sync_cmd = 1'b1;
    push_loads(l + 19, 7, 2);
    @(negedge clk);
    sync_cmd = 1'b0;
    chk(mod_rst == 1'b1, "R8 cmd sets mod_rst", mod_rst, 1);
    @(negedge clk);
    chk(mod_rst == 1'b0, "R8 cmd hold one cycle", mod_rst, 0);
    wait_to(l + 33);
    sync_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, "R1 all expected loads seen", expq.size(), 0);
    done = 1'b1;
    finish_up();
  end
endmodule